// File: doc/BRIEF.md
# Opcode machine-cycle schedule decoder

This block turns an 8-bit opcode into an ordered list of up to five machine cycles for an 8-bit processor core. Each list entry pairs a bus-cycle kind (opcode fetch, memory read, memory write, or an internal cycle of a given number of T-states) with a datapath micro-operation. The micro-operation is applied at the start of the cycle it belongs to. Every list ends with the fetch of the next opcode.

A small controller holds the current list and a step index. The bus sequencer pulses `cycle_end_i` as each machine cycle completes. When the pulse ends a non-fetch entry, the index advances. When the pulse ends the final fetch, the opcode on `opcode_i` is decoded and its list replaces the old one at step 0. The opcode is split into x = bits 7:6, y = bits 5:3 and z = bits 2:0.

The supported groups are:
- 8-bit immediate, register and memory loads;
- 16-bit immediate loads;
- 16-bit add to the HL pair;
- 8-bit adds to A;
- the absolute jump.

HALT and every other opcode decode as a single fetch and raise an error flag.

Top module: `opcode_sched`

## Requirements
- R1: After reset, the current entry is a fetch with no micro-op (all fields 0), `step_o`=0, `decode_err_o`=0 and `pc_inc_o`=0.
- R2: Encodings are as follows.
  - `bus_kind_o`: 0 fetch, 1 memory read, 2 memory write, 3 internal.
  - `addr_hl_o`: 1 when the address comes from HL, 0 when it comes from PC. It is 0 for fetch and internal cycles.
  - `uop_o`: 0 none, 1 8-bit move, 2 8-bit add, 3 16-bit move, 4 16-bit add.
  - 8-bit `dst_o`/`src_o` codes are the y/z register codes, with 6 meaning the data latch and 7 meaning A.
  - 16-bit codes are 0 BC, 1 DE, 2 HL, 3 SP, 4 PC, 5 latch.
  - `dst_o`/`src_o` are 0 when `uop_o`=0. `tstates_o` is 0 except for internal cycles.
- R3: A `cycle_end_i` pulse during a non-fetch entry advances `step_o` by one and ignores `opcode_i`. Without a pulse, every output holds.
- R4: A `cycle_end_i` pulse during a fetch entry decodes `opcode_i`, loads its list and sets `step_o` to 0.
- R5: `pc_inc_o` is high exactly while `cycle_end_i` is high on a memory read addressed by PC.
- R6: Single-fetch lists, each fetch carrying the stated micro-op:
  - NOP (0x00): fetch with no micro-op.
  - x=01 LD r,r': 8-bit move y<-z.
  - x=10 y=000 ADD A,r: 8-bit add A<-z.
- R7: x=00 z=110 with y≠110 (LD r,n) is read via PC, then fetch with move y<-latch. With y=110 (LD (HL),n) it is read via PC, write via HL, fetch.
- R8: x=00 z=001 with even y (LD dd,nn) is two reads via PC, then fetch with 16-bit move pair(y>>1)<-latch. With odd y (ADD HL,ss) it is internal 4, internal 3, then fetch with 16-bit add HL<-pair(y>>1).
- R9: x=01 z=110 y≠110 (LD r,(HL)) is read via HL, then fetch with move y<-latch. x=01 y=110 z≠110 (LD (HL),r) is a write via HL carrying move latch<-z, then fetch. x=10 y=000 z=110 (ADD A,(HL)) is read via HL, then fetch with add A<-latch.
- R10: 0xC6 (ADD A,n) is read via PC, then fetch with add A<-latch. 0xC3 (JP nn) is two reads via PC, then fetch with 16-bit move PC<-latch.
- R11: HALT (0x76) and every opcode not listed above load a single fetch with no micro-op and set `decode_err_o`. The flag holds until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 8 | Opcode byte, sampled when a fetch ends |
| cycle_end_i | input | 1 | Pulse marking the end of the current machine cycle |
| bus_kind_o | output | 2 | Bus-cycle kind of the current entry |
| addr_hl_o | output | 1 | Address source of a memory cycle (1 HL, 0 PC) |
| tstates_o | output | 3 | Length of an internal cycle |
| uop_o | output | 3 | Micro-op applied at the start of this cycle |
| dst_o | output | 3 | Micro-op destination code |
| src_o | output | 3 | Micro-op source code |
| step_o | output | 3 | Index of the current entry |
| decode_err_o | output | 1 | Last loaded opcode was unsupported |
| pc_inc_o | output | 1 | PC must increment at this cycle end |

## Verification
The assertions check the controller on every cycle:
- the step stays in range and advances by one on non-final pulses;
- the step returns to 0 after a final-fetch pulse;
- the step and error flag hold with no pulse;
- an error always coincides with a bare single fetch;
- internal lengths appear only on internal cycles.

Only the bench scenarios can show the decode itself. The bench walks each opcode group through its full list and checks every entry's kind, address source, micro-op and operand codes. It also checks that the opcode driven in mid-list is ignored, and that the error flag clears on the next supported opcode.

// File: rtl/opsched_pkg.sv
package opsched_pkg;
  typedef enum logic [1:0] {BUS_FETCH = 2'd0, BUS_RD = 2'd1, BUS_WR = 2'd2, BUS_INT = 2'd3} bus_kind_e;
  typedef enum logic [2:0] {UOP_NONE = 3'd0, UOP_MOV8 = 3'd1, UOP_ADD8 = 3'd2,
                            UOP_MOV16 = 3'd3, UOP_ADD16 = 3'd4} uop_e;

  localparam logic [2:0] R8_LATCH = 3'd6;
  localparam logic [2:0] R8_A     = 3'd7;
  localparam logic [2:0] W_HL     = 3'd2;
  localparam logic [2:0] W_PC     = 3'd4;
  localparam logic [2:0] W_LATCH  = 3'd5;

  typedef struct packed {
    bus_kind_e  kind;
    logic       addr_hl;
    logic [2:0] tstates;
    uop_e       uop;
    logic [2:0] dst;
    logic [2:0] src;
  } sched_entry_t;

  localparam sched_entry_t ENTRY_FETCH = '{kind: BUS_FETCH, addr_hl: 1'b0, tstates: 3'd0,
                                           uop: UOP_NONE, dst: 3'd0, src: 3'd0};

  function automatic sched_entry_t mk_fetch(uop_e u, logic [2:0] d, logic [2:0] s);
    sched_entry_t e;
    e = ENTRY_FETCH;
    e.uop = u; e.dst = d; e.src = s;
    return e;
  endfunction

  function automatic sched_entry_t mk_mem(bus_kind_e k, logic hl, uop_e u, logic [2:0] d, logic [2:0] s);
    sched_entry_t e;
    e = ENTRY_FETCH;
    e.kind = k; e.addr_hl = hl; e.uop = u; e.dst = d; e.src = s;
    return e;
  endfunction

  function automatic sched_entry_t mk_int(logic [2:0] t);
    sched_entry_t e;
    e = ENTRY_FETCH;
    e.kind = BUS_INT; e.tstates = t;
    return e;
  endfunction
endpackage

// File: rtl/op_decoder.sv
module op_decoder
  import opsched_pkg::*;
#(
  parameter int MAX_CYC = 5
) (
  input  logic [7:0]   opcode_i,
  output sched_entry_t sched_o [MAX_CYC],
  output logic         err_o
);
  logic [1:0] x;
  logic [2:0] y, z, pair;

  assign x    = opcode_i[7:6];
  assign y    = opcode_i[5:3];
  assign z    = opcode_i[2:0];
  assign pair = {1'b0, y[2:1]};

  always_comb begin
    for (int k = 0; k < MAX_CYC; k++) sched_o[k] = ENTRY_FETCH;
    err_o = 1'b0;
    if (opcode_i == 8'h00) begin
      sched_o[0] = ENTRY_FETCH;
    end else if (x == 2'b00 && z == 3'b110) begin
      sched_o[0] = mk_mem(BUS_RD, 1'b0, UOP_NONE, 3'd0, 3'd0);
      if (y == 3'b110) begin
        sched_o[1] = mk_mem(BUS_WR, 1'b1, UOP_NONE, 3'd0, 3'd0);
        sched_o[2] = ENTRY_FETCH;
      end else begin
        sched_o[1] = mk_fetch(UOP_MOV8, y, R8_LATCH);
      end
    end else if (x == 2'b00 && z == 3'b001) begin
      if (!y[0]) begin
        sched_o[0] = mk_mem(BUS_RD, 1'b0, UOP_NONE, 3'd0, 3'd0);
        sched_o[1] = mk_mem(BUS_RD, 1'b0, UOP_NONE, 3'd0, 3'd0);
        sched_o[2] = mk_fetch(UOP_MOV16, pair, W_LATCH);
      end else begin
        sched_o[0] = mk_int(3'd4);
        sched_o[1] = mk_int(3'd3);
        sched_o[2] = mk_fetch(UOP_ADD16, W_HL, pair);
      end
    end else if (x == 2'b01) begin
      if (y == 3'b110 && z == 3'b110) begin
        err_o = 1'b1;  // halt unsupported
      end else if (z == 3'b110) begin
        sched_o[0] = mk_mem(BUS_RD, 1'b1, UOP_NONE, 3'd0, 3'd0);
        sched_o[1] = mk_fetch(UOP_MOV8, y, R8_LATCH);
      end else if (y == 3'b110) begin
        sched_o[0] = mk_mem(BUS_WR, 1'b1, UOP_MOV8, R8_LATCH, z);
        sched_o[1] = ENTRY_FETCH;
      end else begin
        sched_o[0] = mk_fetch(UOP_MOV8, y, z);
      end
    end else if (x == 2'b10 && y == 3'b000) begin
      if (z == 3'b110) begin
        sched_o[0] = mk_mem(BUS_RD, 1'b1, UOP_NONE, 3'd0, 3'd0);
        sched_o[1] = mk_fetch(UOP_ADD8, R8_A, R8_LATCH);
      end else begin
        sched_o[0] = mk_fetch(UOP_ADD8, R8_A, z);
      end
    end else if (opcode_i == 8'hC6) begin
      sched_o[0] = mk_mem(BUS_RD, 1'b0, UOP_NONE, 3'd0, 3'd0);
      sched_o[1] = mk_fetch(UOP_ADD8, R8_A, R8_LATCH);
    end else if (opcode_i == 8'hC3) begin
      sched_o[0] = mk_mem(BUS_RD, 1'b0, UOP_NONE, 3'd0, 3'd0);
      sched_o[1] = mk_mem(BUS_RD, 1'b0, UOP_NONE, 3'd0, 3'd0);
      sched_o[2] = mk_fetch(UOP_MOV16, W_PC, W_LATCH);
    end else begin
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import opsched_pkg::*;
#(
  parameter  int MAX_CYC = 5,
  localparam int STEP_W  = $clog2(MAX_CYC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_end_i,
  input  sched_entry_t      sched_i [MAX_CYC],
  input  logic              err_i,
  output sched_entry_t      cur_o,
  output logic [STEP_W-1:0] step_o,
  output logic              err_o,
  output logic              pc_inc_o
);
  sched_entry_t      sched_q [MAX_CYC];
  logic [STEP_W-1:0] step_q;
  logic              err_q;
  sched_entry_t      cur;
  logic              last;

  assign cur      = (int'(step_q) < MAX_CYC) ? sched_q[step_q] : ENTRY_FETCH;
  assign last     = (cur.kind == BUS_FETCH);
  assign pc_inc_o = cycle_end_i && (cur.kind == BUS_RD) && !cur.addr_hl;
  assign cur_o    = cur;
  assign step_o   = step_q;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_CYC; k++) sched_q[k] <= ENTRY_FETCH;
      step_q <= '0;
      err_q  <= 1'b0;
    end else if (cycle_end_i) begin
      if (last) begin
        for (int k = 0; k < MAX_CYC; k++) sched_q[k] <= sched_i[k];
        step_q <= '0;
        err_q  <= err_i;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assert_step_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(step_q) < MAX_CYC);
  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_i && cur.kind == BUS_FETCH |=> step_q == '0);
  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_i && cur.kind != BUS_FETCH |=> step_q == $past(step_q) + 1'b1);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cycle_end_i |=> $stable(step_q) && $stable(err_q));
  assert_err_nop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> cur.kind == BUS_FETCH && cur.uop == UOP_NONE && step_q == '0);
  assert_tstates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur.kind != BUS_INT |-> cur.tstates == 3'd0);
endmodule

// File: rtl/opcode_sched.sv
module opcode_sched
  import opsched_pkg::*;
#(
  parameter  int MAX_CYC = 5,
  localparam int STEP_W  = $clog2(MAX_CYC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        opcode_i,
  input  logic              cycle_end_i,
  output logic [1:0]        bus_kind_o,
  output logic              addr_hl_o,
  output logic [2:0]        tstates_o,
  output logic [2:0]        uop_o,
  output logic [2:0]        dst_o,
  output logic [2:0]        src_o,
  output logic [STEP_W-1:0] step_o,
  output logic              decode_err_o,
  output logic              pc_inc_o
);
  sched_entry_t dec_sched [MAX_CYC];
  logic         dec_err;
  sched_entry_t cur;

  op_decoder #(.MAX_CYC(MAX_CYC)) u_dec (
    .opcode_i (opcode_i),
    .sched_o  (dec_sched),
    .err_o    (dec_err)
  );

  sched_ctrl #(.MAX_CYC(MAX_CYC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cycle_end_i (cycle_end_i),
    .sched_i     (dec_sched),
    .err_i       (dec_err),
    .cur_o       (cur),
    .step_o      (step_o),
    .err_o       (decode_err_o),
    .pc_inc_o    (pc_inc_o)
  );

  assign bus_kind_o = cur.kind;
  assign addr_hl_o  = cur.addr_hl;
  assign tstates_o  = cur.tstates;
  assign uop_o      = cur.uop;
  assign dst_o      = cur.dst;
  assign src_o      = cur.src;
endmodule

// File: tb/sim_opcode_sched.sv
module sim_opcode_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opcode_i = 8'h00;
  logic       cycle_end_i = 1'b0;
  logic [1:0] bus_kind_o;
  logic       addr_hl_o, decode_err_o, pc_inc_o;
  logic [2:0] tstates_o, uop_o, dst_o, src_o, step_o;

  typedef struct packed {
    logic [1:0] kind; logic hl; logic [2:0] t; logic [2:0] uop;
    logic [2:0] dst; logic [2:0] src; logic [2:0] step; logic err; logic pci;
  } exp_t;

  exp_t  q[$];
  string tag_q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  exp_t  prev;

  always #4 clk = ~clk;

  opcode_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode_i), .cycle_end_i(cycle_end_i),
    .bus_kind_o(bus_kind_o), .addr_hl_o(addr_hl_o), .tstates_o(tstates_o),
    .uop_o(uop_o), .dst_o(dst_o), .src_o(src_o), .step_o(step_o),
    .decode_err_o(decode_err_o), .pc_inc_o(pc_inc_o)
  );

  function automatic exp_t mk(logic [1:0] k, logic hl, logic [2:0] t, logic [2:0] u,
                              logic [2:0] d, logic [2:0] s);
    exp_t e;
    e = '{kind: k, hl: hl, t: t, uop: u, dst: d, src: s, step: 3'd0, err: 1'b0,
          pci: (k == 2'd1 && !hl)};
    return e;
  endfunction

  // expected list per requirements R6..R11
  function automatic int model(input logic [7:0] op, output exp_t e [3]);
    logic [1:0] x; logic [2:0] y, z; int n; bit err;
    x = op[7:6]; y = op[5:3]; z = op[2:0]; err = 0;
    for (int k = 0; k < 3; k++) e[k] = mk(0, 0, 0, 0, 0, 0);
    n = 1;
    if (op == 8'h00) n = 1;
    else if (x == 0 && z == 6 && y != 6) begin n = 2; e[0] = mk(1,0,0,0,0,0); e[1] = mk(0,0,0,1,y,6); end
    else if (op == 8'h36) begin n = 3; e[0] = mk(1,0,0,0,0,0); e[1] = mk(2,1,0,0,0,0); end
    else if (x == 0 && z == 1 && !y[0]) begin
      n = 3; e[0] = mk(1,0,0,0,0,0); e[1] = mk(1,0,0,0,0,0); e[2] = mk(0,0,0,3,{1'b0,y[2:1]},5);
    end else if (x == 0 && z == 1) begin
      n = 3; e[0] = mk(3,0,4,0,0,0); e[1] = mk(3,0,3,0,0,0); e[2] = mk(0,0,0,4,2,{1'b0,y[2:1]});
    end else if (op == 8'h76) err = 1;
    else if (x == 1 && z == 6) begin n = 2; e[0] = mk(1,1,0,0,0,0); e[1] = mk(0,0,0,1,y,6); end
    else if (x == 1 && y == 6) begin n = 2; e[0] = mk(2,1,0,1,6,z); end
    else if (x == 1) e[0] = mk(0,0,0,1,y,z);
    else if (op == 8'h86) begin n = 2; e[0] = mk(1,1,0,0,0,0); e[1] = mk(0,0,0,2,7,6); end
    else if (x == 2 && y == 0) e[0] = mk(0,0,0,2,7,z);
    else if (op == 8'hC6) begin n = 2; e[0] = mk(1,0,0,0,0,0); e[1] = mk(0,0,0,2,7,6); end
    else if (op == 8'hC3) begin
      n = 3; e[0] = mk(1,0,0,0,0,0); e[1] = mk(1,0,0,0,0,0); e[2] = mk(0,0,0,3,4,5);
    end else err = 1;
    for (int k = 0; k < 3; k++) begin e[k].step = 3'(k); e[k].err = err; end
    return n;
  endfunction

  task automatic pulse(input logic [7:0] op);
    @(negedge clk); opcode_i = op; cycle_end_i = 1'b1;
    @(negedge clk); cycle_end_i = 1'b0; opcode_i = 8'h00;
  endtask

  // driver: R4 load on final fetch, R3 mid-list pulses carry a junk opcode
  task automatic exec(input logic [7:0] op, input string tag);
    exp_t e [3]; int n;
    n = model(op, e);
    q.push_back(prev); tag_q.push_back("R4");
    pulse(op);
    for (int k = 0; k < n - 1; k++) begin
      q.push_back(e[k]); tag_q.push_back(tag);
      pulse(~op);
    end
    prev = e[n-1];
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && cycle_end_i && !done) begin
      exp_t act, ex; string tg;
      act = '{kind: bus_kind_o, hl: addr_hl_o, t: tstates_o, uop: uop_o, dst: dst_o,
              src: src_o, step: step_o, err: decode_err_o, pci: pc_inc_o};
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++; $display("FAIL R3: unexpected cycle end, actual %h expected none", act);
      end else begin
        ex = q.pop_front(); tg = tag_q.pop_front();
        if (act !== ex) begin
          n_bad++;
          $display("FAIL %s (R2/R5 fields): actual %h expected %h", tg, act, ex);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1; n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    prev = mk(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    n_cmp++;  // R1 reset state
    if ({bus_kind_o, addr_hl_o, tstates_o, uop_o, dst_o, src_o, step_o, decode_err_o, pc_inc_o} !== '0) begin
      n_bad++; $display("FAIL R1: actual %b expected all zero",
        {bus_kind_o, addr_hl_o, tstates_o, uop_o, dst_o, src_o, step_o, decode_err_o, pc_inc_o});
    end
    exec(8'h00, "R6");  // NOP
    exec(8'h78, "R6");  // LD A,B
    exec(8'h41, "R6");
    exec(8'h80, "R6");  // ADD A,B
    exec(8'h87, "R6");
    exec(8'h3E, "R7");  // LD A,n
    exec(8'h06, "R7");
    exec(8'h36, "R7");  // LD (HL),n
    exec(8'h01, "R8");
    exec(8'h11, "R8");
    exec(8'h21, "R8");
    exec(8'h31, "R8");
    exec(8'h09, "R8");  // ADD HL,BC
    exec(8'h39, "R8");
    exec(8'h46, "R9");  // LD B,(HL)
    exec(8'h7E, "R9");
    exec(8'h77, "R9");  // LD (HL),A
    exec(8'h70, "R9");
    exec(8'h86, "R9");  // ADD A,(HL)
    exec(8'hC6, "R10"); // ADD A,n
    exec(8'hC3, "R10"); // JP nn
    exec(8'h76, "R11"); // HALT
    exec(8'hCB, "R11");
    exec(8'h3C, "R11");
    exec(8'h4F, "R11"); // error flag clears on next load
    exec(8'h00, "R5");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3: actual %0d pending expected 0", q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule